// File: doc/BRIEF.md
# Power-Mode-Aware Watchdog Timer

This block is a watchdog counter that software must service at regular intervals. If the count reaches the timeout without a service, the block raises a reset pulse that lasts several clocks, and the count starts again from zero. Software services the watchdog by writing to a small control register. A write with bit 0 at logic 0 restarts the count. A write with bit 0 at logic 1 does nothing to the counter. The same register also holds an optional-features flag that software can read and write.

Whether the counter runs depends on the processor's requested low-power state, on a one-time enable option, on a stop-to-halt option and on a digital overvoltage flag from the programming pin. A stop request clears the counter and keeps it gated for as long as the request lasts. When the stop-to-halt option is set, the block turns a stop request into a halt request, and the counter keeps running. The block also outputs the effective power mode after this conversion, for the clock controller to use. Whenever counting resumes after a pause, the count starts again from zero.

Top module: `mode_wdog`

## Requirements
- R1: While rst_ni is low, wdt_rst_o is low and the count is zero. The first timeout comes exactly 2^TMO_LOG2 clock edges after reset is released, if nothing services the watchdog and the watchdog is active.
- R2: A write with wr_data_i[0]=0 clears the count at that clock edge. Servicing more often than the timeout period keeps wdt_rst_o low.
- R3: A write with wr_data_i[0]=1 leaves the count unchanged.
- R4: The register reads back as rd_data_o = {zeros, opt, 0}. Bit 0 (the service bit) always reads 0, and bits 7..2 always read 0.
- R5: If the watchdog stays active with no service for 2^TMO_LOG2 consecutive edges, wdt_rst_o goes high for PULSE_LEN cycles, starting one cycle after the final edge. The count wraps to zero and keeps running.
- R6: While cfg_en_i is 0, the count stays at zero and no timeout occurs. Counting restarts from zero once cfg_en_i is set again.
- R7: pwr_req_i encodes run=0, wait=1, halt=2 and stop=3. A stop request with cfg_stop_halt_i=0 holds the count at zero, and pwr_mode_o reads 3. After the request ends, counting restarts from zero.
- R8: A stop request with cfg_stop_halt_i=1 gives pwr_mode_o=2 (halt), and the watchdog keeps counting.
- R9: The watchdog counts in the run, wait and halt modes, and pwr_mode_o equals pwr_req_i in these modes.
- R10: While hv_flag_i is high, the count stays at zero and no timeout occurs. Counting restarts from zero once the flag drops.
- R11: The optional-features bit is written from wr_data_i[1] on any write. Reset does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Write data: bit 0 is the service bit, bit 1 is the optional-features bit |
| rd_data_o | output | 8 | Control register read data |
| pwr_req_i | input | 2 | Requested power mode (0 run, 1 wait, 2 halt, 3 stop) |
| cfg_en_i | input | 1 | Watchdog enable option |
| cfg_stop_halt_i | input | 1 | Converts stop requests into halt requests |
| hv_flag_i | input | 1 | Overvoltage on the programming pin; suspends the watchdog |
| pwr_mode_o | output | 2 | Effective power mode after conversion |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The assertions assume that every input is synchronous to clk_i and stays stable between edges. They also assume that the option bits and the overvoltage flag are plain levels, so any value combination may occur in any cycle. The stimulus keeps to these assumptions by changing inputs only just after a rising edge. It also changes the option bits, the power request and the overvoltage flag at random in every combination, including stop requests and overvoltage during a reset pulse.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_WAIT = 2'd1,
    PM_HALT = 2'd2,
    PM_STOP = 2'd3
  } pwr_mode_e;
endpackage

// File: rtl/wdog_mode_ctrl.sv
`timescale 1ns/1ps
module wdog_mode_ctrl
  import wdog_pkg::*;
(
  input  pwr_mode_e req_i,
  input  logic      en_i,
  input  logic      stop_halt_i,
  input  logic      hv_i,
  output pwr_mode_e mode_o,
  output logic      run_o
);
  always_comb begin
    mode_o = req_i;
    if (req_i == PM_STOP && stop_halt_i) mode_o = PM_HALT;
  end

  // stop gates the count clock; overvoltage holds it off
  assign run_o = en_i && !hv_i && (mode_o != PM_STOP);
endmodule

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              svc_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic opt_q;

  // optional-features bit keeps its value across reset
  always_ff @(posedge clk_i) begin
    if (wr_en_i) opt_q <= wr_data_i[1];
  end

  assign svc_o = wr_en_i && !wr_data_i[0];

  always_comb begin
    rd_data_o    = '0;
    rd_data_o[1] = opt_q;
  end
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             svc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && !svc_i && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || svc_i)     cnt_q <= '0;
    else                          cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_pulse.sv
`timescale 1ns/1ps
module wdog_pulse #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int unsigned PW = (PULSE_LEN < 2) ? 1 : $clog2(PULSE_LEN + 1);

  if (PULSE_LEN <= 1) begin : g_single
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= fire_i;
    end
    assign pulse_o = q;
  end else begin : g_stretch
    logic [PW-1:0] left_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              left_q <= '0;
      else if (fire_i)          left_q <= PW'(PULSE_LEN);
      else if (left_q != '0)    left_q <= left_q - PW'(1);
    end
    assign pulse_o = (left_q != '0);
  end
endmodule

// File: rtl/mode_wdog.sv
`timescale 1ns/1ps
module mode_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned TMO_LOG2  = 12,
  parameter int unsigned PULSE_LEN = 16,
  parameter int unsigned DATA_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [1:0]        pwr_req_i,
  input  logic              cfg_en_i,
  input  logic              cfg_stop_halt_i,
  input  logic              hv_flag_i,
  output logic [1:0]        pwr_mode_o,
  output logic              wdt_rst_o
);
  pwr_mode_e          mode;
  logic               run, svc, expire;
  logic [TMO_LOG2-1:0] cnt_q;

  wdog_mode_ctrl i_mode (
    .req_i      (pwr_mode_e'(pwr_req_i)),
    .en_i       (cfg_en_i),
    .stop_halt_i(cfg_stop_halt_i),
    .hv_i       (hv_flag_i),
    .mode_o     (mode),
    .run_o      (run)
  );

  wdog_regs #(.DATA_W(DATA_W)) i_regs (
    .clk_i    (clk_i),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .svc_o    (svc),
    .rd_data_o(rd_data_o)
  );

  wdog_counter #(.CNT_W(TMO_LOG2)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .svc_i   (svc),
    .cnt_o   (cnt_q),
    .expire_o(expire)
  );

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) i_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (expire),
    .pulse_o(wdt_rst_o)
  );

  assign pwr_mode_o = mode;
endmodule

// File: rtl/wdog_chk.sv
`timescale 1ns/1ps
module wdog_chk #(
  parameter int unsigned TMO_LOG2 = 12,
  parameter int unsigned DATA_W   = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [DATA_W-1:0]   wr_data_i,
  input logic [DATA_W-1:0]   rd_data_o,
  input logic [1:0]          pwr_req_i,
  input logic                cfg_en_i,
  input logic                cfg_stop_halt_i,
  input logic                hv_flag_i,
  input logic [1:0]          pwr_mode_o,
  input logic                wdt_rst_o,
  input logic [TMO_LOG2-1:0] cnt_i
);
  logic svc, act;
  assign svc = wr_en_i && !wr_data_i[0];
  assign act = cfg_en_i && !hv_flag_i && !(pwr_req_i == 2'd3 && !cfg_stop_halt_i);

  // R4
  svc_bit_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[0] == 1'b0);

  // R2
  svc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc |=> cnt_i == '0);

  // R6
  en_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> cnt_i == '0);

  // R7
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_req_i == 2'd3 && !cfg_stop_halt_i) |=> cnt_i == '0);

  // R8
  stop_to_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_req_i == 2'd3 && cfg_stop_halt_i) |-> pwr_mode_o == 2'd2);

  // R10
  hv_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_flag_i |=> cnt_i == '0);

  // R5
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && !svc && cnt_i != '1) |=> cnt_i == $past(cnt_i) + TMO_LOG2'(1));

  // R5
  expire_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && !svc && cnt_i == '1) |=> (wdt_rst_o && cnt_i == '0));
endmodule

bind mode_wdog wdog_chk #(.TMO_LOG2(TMO_LOG2), .DATA_W(DATA_W)) i_wdog_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .wr_data_i      (wr_data_i),
  .rd_data_o      (rd_data_o),
  .pwr_req_i      (pwr_req_i),
  .cfg_en_i       (cfg_en_i),
  .cfg_stop_halt_i(cfg_stop_halt_i),
  .hv_flag_i      (hv_flag_i),
  .pwr_mode_o     (pwr_mode_o),
  .wdt_rst_o      (wdt_rst_o),
  .cnt_i          (cnt_q)
);

// File: tb/test_mode_wdog.sv
`timescale 1ns/1ps
module test_mode_wdog;
  localparam int TL  = 6;
  localparam int TMO = 1 << TL;
  localparam int PL  = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h01;
  logic [7:0] rd_data_o;
  logic [1:0] pwr_req_i = 2'd0;
  logic       cfg_en_i = 1'b1;
  logic       cfg_stop_halt_i = 1'b0;
  logic       hv_flag_i = 1'b0;
  logic [1:0] pwr_mode_o;
  logic       wdt_rst_o;

  int    total = 0, bad = 0;
  int    m_cnt = 0, m_pls = 0;
  bit    seen = 0, done = 0;
  string tag = "R1";

  always #2.5 clk_i = ~clk_i;

  mode_wdog #(.TMO_LOG2(TL), .PULSE_LEN(PL)) i_mode_wdog (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_mode(input logic [1:0] r, input logic sh);
    return (r == 2'd3 && sh) ? 2 : int'(r);
  endfunction

  function automatic bit exp_active();
    return cfg_en_i && !hv_flag_i && !(pwr_req_i == 2'd3 && !cfg_stop_halt_i);
  endfunction

  // reference model from the requirements
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt <= 0; m_pls <= 0;
    end else begin
      automatic bit sv = wr_en_i && !wr_data_i[0];
      automatic bit ex = exp_active() && !sv && m_cnt == TMO - 1;
      m_cnt <= (!exp_active() || sv || ex) ? 0 : m_cnt + 1;
      m_pls <= ex ? PL : (m_pls > 0 ? m_pls - 1 : 0);
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (wdt_rst_o) seen = 1;
      chk(wdt_rst_o == (m_pls != 0), tag, int'(wdt_rst_o), int'(m_pls != 0));
      chk(int'(pwr_mode_o) == exp_mode(pwr_req_i, cfg_stop_halt_i), "R9",
          int'(pwr_mode_o), exp_mode(pwr_req_i, cfg_stop_halt_i));
      chk(rd_data_o[0] == 1'b0 && rd_data_o[7:2] == 6'd0, "R4",
          int'(rd_data_o), int'({6'd0, rd_data_o[1], 1'b0}));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic service();
    wr_en_i = 1'b1; wr_data_i = 8'h00;
    step(1);
    wr_en_i = 1'b0; wr_data_i = 8'h01;
  endtask

  task automatic settle();
    step(PL + 2);
    seen = 0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state and first timeout
    step(2);
    chk(wdt_rst_o == 1'b0, "R1", int'(wdt_rst_o), 0);
    rst_ni = 1'b1;
    step(TMO - 1);
    chk(wdt_rst_o == 1'b0, "R1", int'(wdt_rst_o), 0);
    step(1);
    chk(wdt_rst_o == 1'b1, "R5", int'(wdt_rst_o), 1);
    step(PL - 1);
    chk(wdt_rst_o == 1'b1, "R5", int'(wdt_rst_o), 1);
    step(1);
    chk(wdt_rst_o == 1'b0, "R5", int'(wdt_rst_o), 0);

    // R3: writes of 1 do not restart
    tag = "R3"; settle(); service();
    wr_en_i = 1'b1; wr_data_i = 8'hFF;
    step(TMO);
    chk(wdt_rst_o == 1'b1, "R3", int'(wdt_rst_o), 1);
    wr_en_i = 1'b0; wr_data_i = 8'h01;

    // R2: periodic service keeps reset low
    tag = "R2"; settle();
    for (int i = 0; i < 10; i++) begin service(); step(TMO / 2); end
    chk(seen == 0, "R2", int'(seen), 0);

    // R9: wait and halt both count
    tag = "R9";
    for (int m = 1; m <= 2; m++) begin
      settle(); pwr_req_i = 2'(m); service();
      step(TMO);
      chk(wdt_rst_o == 1'b1, "R9", int'(wdt_rst_o), 1);
    end
    pwr_req_i = 2'd0;

    // R6: enable option off
    tag = "R6"; settle(); cfg_en_i = 1'b0;
    step(5 * TMO);
    chk(seen == 0, "R6", int'(seen), 0);
    cfg_en_i = 1'b1;
    step(TMO - 1);
    chk(wdt_rst_o == 1'b0, "R6", int'(wdt_rst_o), 0);
    step(1);
    chk(wdt_rst_o == 1'b1, "R6", int'(wdt_rst_o), 1);

    // R7: stop clears and gates
    tag = "R7"; settle(); step(TMO / 2); pwr_req_i = 2'd3;
    step(4 * TMO);
    chk(seen == 0, "R7", int'(seen), 0);
    chk(pwr_mode_o == 2'd3, "R7", int'(pwr_mode_o), 3);
    pwr_req_i = 2'd0;
    step(TMO - 1);
    chk(wdt_rst_o == 1'b0, "R7", int'(wdt_rst_o), 0);
    step(1);
    chk(wdt_rst_o == 1'b1, "R7", int'(wdt_rst_o), 1);

    // R8: stop converted to halt keeps counting
    tag = "R8"; settle(); cfg_stop_halt_i = 1'b1; pwr_req_i = 2'd3; service();
    chk(pwr_mode_o == 2'd2, "R8", int'(pwr_mode_o), 2);
    step(TMO);
    chk(wdt_rst_o == 1'b1, "R8", int'(wdt_rst_o), 1);
    pwr_req_i = 2'd0; cfg_stop_halt_i = 1'b0;

    // R10: overvoltage holds off
    tag = "R10"; settle(); step(TMO / 3); hv_flag_i = 1'b1;
    step(5 * TMO);
    chk(seen == 0, "R10", int'(seen), 0);
    hv_flag_i = 1'b0;
    step(TMO - 1);
    chk(wdt_rst_o == 1'b0, "R10", int'(wdt_rst_o), 0);
    step(1);
    chk(wdt_rst_o == 1'b1, "R10", int'(wdt_rst_o), 1);

    // R11: optional bit written and kept over reset
    tag = "R11"; settle();
    wr_en_i = 1'b1; wr_data_i = 8'h02; step(1); wr_en_i = 1'b0; wr_data_i = 8'h01;
    chk(rd_data_o == 8'h02, "R11", int'(rd_data_o), 2);
    rst_ni = 1'b0; step(2);
    chk(rd_data_o == 8'h02, "R11", int'(rd_data_o), 2);
    chk(wdt_rst_o == 1'b0, "R1", int'(wdt_rst_o), 0);
    rst_ni = 1'b1;
    wr_en_i = 1'b1; wr_data_i = 8'h01; step(1); wr_en_i = 1'b0;
    chk(rd_data_o == 8'h00, "R11", int'(rd_data_o), 0);

    // random mix
    tag = "R5";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 49) == 0)  pwr_req_i = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 299) == 0) hv_flag_i = ~hv_flag_i;
      if ($urandom_range(0, 399) == 0) cfg_en_i = ~cfg_en_i;
      if ($urandom_range(0, 249) == 0) cfg_stop_halt_i = ~cfg_stop_halt_i;
      wr_en_i   = ($urandom_range(0, 29) == 0);
      wr_data_i = 8'($urandom);
      step(1);
    end
    wr_en_i = 1'b0;
    step(2);
    finish_up();
  end
endmodule